// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a reference clock enable, asserted once per cycle of a 32768 Hz
reference, into a one-second tick. It keeps the long-term rate accurate by
changing the length of a single second in each correction window. The window is
10 or 30 seconds long. A signed trim word sets how many reference cycles that
second gains or loses. All other seconds in the window last exactly the nominal
count. For a 10-second window, one cycle per window is about 3.05 ppm, and the
full trim span is about ±192 ppm. For a 30-second window, one cycle is about
1.02 ppm, and the full span is about ±64 ppm.

The block also drives two groups of frequency taps. The fast taps come from a
free-running count of reference pulses and never see the trim. The slow taps run
at 1 Hz and below, and they follow the trimmed seconds. The trim word and the
window select are captured only at a window boundary. A host can therefore
rewrite them at any time without making a partial correction. All pins are plain
level or pulse signals. Nothing streams through the block, so there is no
handshake and no back-pressure.

Top module: `trim_prescaler`

## Requirements
- R1: While reset is held and just after it is released, `sec_tick`, `corr_sec`, `raw_taps` and `slow_taps` are all zero.
- R2: A second that is not the correction second lasts exactly 2^DIV_W accepted reference pulses.
- R3: Trim encoding is as follows. Bit TRIM_W-1 is the sign: 0 means a positive trim, which shortens the correction second and makes the clock faster; 1 means a negative trim, which lengthens it. The lower TRIM_W-1 bits hold the magnitude M. The correction second therefore lasts 2^DIV_W - M pulses for a positive trim and 2^DIV_W + M pulses for a negative trim. This holds for every M from 0 to 63.
- R4: A magnitude of zero yields exactly 2^DIV_W pulses in every second, whatever the sign bit is.
- R5: The correction second is the last second of its window. With `period_sel` = 0 the window is WIN_SHORT seconds long. With `period_sel` = 1 it is WIN_LONG seconds long.
- R6: `corr_sec` is high for exactly the correction second. It rises in the same cycle as the tick that ends the second before it, and it falls with the tick that ends the correction second.
- R7: `trim_code` and `period_sel` are captured while `enable` is low and at the end of each window. A change in the middle of a window first acts on the next window.
- R8: While `enable` is low, the block counts nothing and issues no tick. One cycle after `enable` goes low, all outputs are zero. When `enable` goes high again, a fresh window starts from its first second.
- R9: A clock cycle with `ref_en` low does not advance any count.
- R10: `raw_taps` is a count of accepted reference pulses, modulo 2^(DIV_W-1). Bit k therefore toggles every 2^k pulses and is never trimmed.
- R11: `slow_taps[0]` is high while the position in the current second is at or beyond 2^(DIV_W-1). Bit k, for k ≥ 1, is bit k-1 of a count of completed seconds since enable. These bits therefore change only with a tick.
- R12: `sec_tick` is high for one cycle. That cycle directly follows the cycle whose accepted reference pulse completes a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One reference pulse per cycle in which it is high |
| enable | input | 1 | Run control; low clears and holds the divider |
| trim_code | input | TRIM_W | Sign and magnitude trim word |
| period_sel | input | 1 | Window select: 0 short, 1 long |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| corr_sec | output | 1 | High during the correction second |
| raw_taps | output | DIV_W-1 | Untrimmed reference divider taps |
| slow_taps | output | SLOW_TAPS | Trimmed taps at 1 Hz and below |

## Verification
The bench builds the block with DIV_W = 6, so a nominal second is 64 reference pulses. It keeps the full 7-bit trim word and the true 10- and 30-second windows. With these values a whole long window takes about two thousand cycles. Both extremes of the trim become reachable: a one-pulse second at +63 and a 127-pulse second at -63. Windows whose select bit is changed part-way through, and runs with a gapped reference enable, can also be compared second by second against the reference model.

// File: rtl/trim_prescaler_pkg.sv
package trim_prescaler_pkg;

  // Correction window length select, as captured at a window boundary
  typedef enum logic {
    WIN_SHORT_SEL = 1'b0,
    WIN_LONG_SEL  = 1'b1
  } win_sel_e;

endpackage

// File: rtl/trim_window_latch.sv
module trim_window_latch
  import trim_prescaler_pkg::*;
#(
  parameter int TRIM_W    = 7,
  parameter int WIN_SHORT = 10,
  parameter int WIN_LONG  = 30,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TRIM_W-1:0] trim_in,
  input  logic              period_in,
  output logic [TRIM_W-1:0] trim_q,
  output logic [IDX_W-1:0]  last_idx
);

  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(WIN_SHORT - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(WIN_LONG - 1);

  win_sel_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
      sel_q  <= WIN_SHORT_SEL;
    end else if (load) begin
      trim_q <= trim_in;
      sel_q  <= win_sel_e'(period_in);
    end
  end

  assign last_idx = (sel_q == WIN_LONG_SEL) ? LAST_LONG : LAST_SHORT;

endmodule

// File: rtl/second_divider.sv
module second_divider #(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ref_en,
  input  logic              corr,
  input  logic [TRIM_W-1:0] trim,
  output logic [DIV_W:0]    cnt_q,
  output logic [DIV_W:0]    cnt_last,
  output logic              sec_end
);

  localparam int CNT_W = DIV_W + 1;
  localparam int MAG_W = TRIM_W - 1;
  localparam logic [CNT_W-1:0] NOM_LAST = CNT_W'((1 << DIV_W) - 1);

  logic [CNT_W-1:0] mag_ext;

  assign mag_ext = {{(CNT_W-MAG_W){1'b0}}, trim[MAG_W-1:0]};

  // Final count value of the running second: nominal, or trimmed by +/- magnitude
  always_comb begin
    cnt_last = NOM_LAST;
    if (corr) begin
      cnt_last = trim[MAG_W] ? (NOM_LAST + mag_ext) : (NOM_LAST - mag_ext);
    end
  end

  assign sec_end = ref_en & ~clear & (cnt_q == cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (ref_en) begin
      cnt_q <= sec_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/window_sequencer.sv
module window_sequencer #(
  parameter int IDX_W = 5,
  parameter int SEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sec_end,
  input  logic [IDX_W-1:0] last_idx,
  output logic             corr,
  output logic [SEC_W-1:0] secs_q
);

  logic [IDX_W-1:0] idx_q;

  assign corr = (idx_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      secs_q <= '0;
    end else if (clear) begin
      idx_q  <= '0;
      secs_q <= '0;
    end else if (sec_end) begin
      idx_q  <= corr ? '0 : idx_q + 1'b1;
      secs_q <= secs_q + 1'b1;
    end
  end

endmodule

// File: rtl/tap_generator.sv
module tap_generator #(
  parameter int DIV_W     = 15,
  parameter int SLOW_TAPS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 ref_en,
  input  logic                 sec_end,
  input  logic [DIV_W:0]       cnt,
  input  logic [SLOW_TAPS-2:0] secs,
  output logic                 tick,
  output logic [DIV_W-2:0]     raw_taps,
  output logic [SLOW_TAPS-1:0] slow_taps
);

  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (DIV_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= 1'b0;
      raw_taps <= '0;
    end else if (clear) begin
      tick     <= 1'b0;
      raw_taps <= '0;
    end else begin
      tick <= sec_end;
      if (ref_en) begin
        raw_taps <= raw_taps + 1'b1;
      end
    end
  end

  assign slow_taps[0] = (cnt >= HALF);

  for (genvar k = 1; k < SLOW_TAPS; k++) begin : g_slow
    assign slow_taps[k] = secs[k-1];
  end

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler #(
  parameter int DIV_W     = 15,
  parameter int TRIM_W    = 7,
  parameter int WIN_SHORT = 10,
  parameter int WIN_LONG  = 30,
  parameter int SLOW_TAPS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_en,
  input  logic                 enable,
  input  logic [TRIM_W-1:0]    trim_code,
  input  logic                 period_sel,
  output logic                 sec_tick,
  output logic                 corr_sec,
  output logic [DIV_W-2:0]     raw_taps,
  output logic [SLOW_TAPS-1:0] slow_taps
);

  localparam int CNT_W = DIV_W + 1;
  localparam int IDX_W = $clog2(WIN_LONG);
  localparam int SEC_W = SLOW_TAPS - 1;

  logic              clear;
  logic              win_load;
  logic              sec_end;
  logic [TRIM_W-1:0] trim_act;
  logic [IDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [CNT_W-1:0]  cyc_last;
  logic [SEC_W-1:0]  secs;

  assign clear    = ~enable;
  assign win_load = clear | (sec_end & corr_sec);

  trim_window_latch #(
    .TRIM_W(TRIM_W), .WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG), .IDX_W(IDX_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load(win_load),
    .trim_in(trim_code), .period_in(period_sel),
    .trim_q(trim_act), .last_idx(last_idx)
  );

  second_divider #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ref_en(ref_en),
    .corr(corr_sec), .trim(trim_act),
    .cnt_q(cyc_cnt), .cnt_last(cyc_last), .sec_end(sec_end)
  );

  window_sequencer #(
    .IDX_W(IDX_W), .SEC_W(SEC_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sec_end(sec_end),
    .last_idx(last_idx), .corr(corr_sec), .secs_q(secs)
  );

  tap_generator #(
    .DIV_W(DIV_W), .SLOW_TAPS(SLOW_TAPS)
  ) u_taps (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ref_en(ref_en),
    .sec_end(sec_end), .cnt(cyc_cnt), .secs(secs),
    .tick(sec_tick), .raw_taps(raw_taps), .slow_taps(slow_taps)
  );

endmodule

// File: rtl/trim_prescaler_chk.sv
module trim_prescaler_chk #(
  parameter int DIV_W     = 15,
  parameter int SLOW_TAPS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_en,
  input logic                 enable,
  input logic                 sec_tick,
  input logic                 corr_sec,
  input logic [DIV_W-2:0]     raw_taps,
  input logic [SLOW_TAPS-1:0] slow_taps,
  input logic [DIV_W:0]       cyc_cnt,
  input logic [DIV_W:0]       cyc_last
);

  // R12
  tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> ($past(ref_en) && $past(enable)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sec_tick && !corr_sec && raw_taps == '0 && slow_taps == '0));

  // R6
  corr_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corr_sec) |-> sec_tick);

  // R6
  corr_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(corr_sec) |-> (sec_tick || !$past(enable)));

  // R11
  slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slow_taps[SLOW_TAPS-1:1]) |-> (sec_tick || !$past(enable)));

  // R9
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(ref_en)) |-> $stable(raw_taps));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_cnt <= cyc_last);

endmodule

bind trim_prescaler trim_prescaler_chk #(
  .DIV_W(DIV_W), .SLOW_TAPS(SLOW_TAPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .enable(enable),
  .sec_tick(sec_tick), .corr_sec(corr_sec), .raw_taps(raw_taps),
  .slow_taps(slow_taps), .cyc_cnt(cyc_cnt), .cyc_last(cyc_last)
);

// File: tb/test_trim_prescaler.sv
module test_trim_prescaler;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 6;
  localparam int TW   = 7;
  localparam int WS   = 10;
  localparam int WL   = 30;
  localparam int ST   = 6;
  localparam int NOM  = 1 << DW;
  localparam int WDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_en = 1'b1;
  logic          enable = 1'b0;
  logic [TW-1:0] trim_code = '0;
  logic          period_sel = 1'b0;
  logic          sec_tick;
  logic          corr_sec;
  logic [DW-2:0] raw_taps;
  logic [ST-1:0] slow_taps;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit gap = 0;
  int phase = 0;
  int lens[$];
  int run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_prescaler #(
    .DIV_W(DW), .TRIM_W(TW), .WIN_SHORT(WS), .WIN_LONG(WL), .SLOW_TAPS(ST)
  ) i_trim_prescaler (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .enable(enable),
    .trim_code(trim_code), .period_sel(period_sel),
    .sec_tick(sec_tick), .corr_sec(corr_sec),
    .raw_taps(raw_taps), .slow_taps(slow_taps)
  );

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model, behavioural
  int m_cnt = 0, m_idx = 0, m_secs = 0, m_raw = 0;
  bit m_tick = 0;
  logic [TW-1:0] m_trim = '0;
  bit m_per = 0;

  function automatic int win_len(input bit per);
    return per ? WL : WS;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_secs = 0; m_raw = 0; m_tick = 0;
      m_trim = '0; m_per = 0;
    end else if (!enable) begin
      m_cnt = 0; m_idx = 0; m_secs = 0; m_raw = 0; m_tick = 0;
      m_trim = trim_code; m_per = period_sel;
    end else begin
      m_tick = 0;
      if (ref_en) begin
        int sv, len;
        bit last;
        m_raw = (m_raw + 1) % (NOM / 2);
        last = (m_idx == win_len(m_per) - 1);
        sv = int'(m_trim[TW-2:0]);
        if (m_trim[TW-1]) sv = -sv;
        len = last ? NOM - sv : NOM;
        if (m_cnt == len - 1) begin
          m_cnt = 0; m_tick = 1; m_secs = (m_secs + 1) % 32;
          if (last) begin
            m_idx = 0; m_trim = trim_code; m_per = period_sel;
          end else begin
            m_idx++;
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // Second length monitor, in accepted reference pulses
  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      run = 0;
    end else begin
      if (sec_tick) begin
        lens.push_back(run);
        run = 0;
      end
      if (ref_en) run++;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int e_slow;
      e_slow = ((m_secs % 32) << 1) | ((m_cnt >= NOM / 2) ? 1 : 0);
      check_int("R12", "sec_tick", int'(sec_tick), int'(m_tick));
      check_int("R6", "corr_sec", int'(corr_sec), (m_idx == win_len(m_per) - 1) ? 1 : 0);
      check_int("R10", "raw_taps", int'(raw_taps), m_raw);
      check_int("R11", "slow_taps", int'(slow_taps), e_slow);
    end
  end

  // Reference enable pattern
  always @(negedge clk) begin
    if (gap) begin
      phase = (phase + 1) % 3;
      ref_en = (phase == 0);
    end else begin
      ref_en = 1'b1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      miscompares++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic start_run(input logic [TW-1:0] t, input bit p, input bit g);
    @(negedge clk);
    enable = 1'b0;
    trim_code = t;
    period_sel = p;
    gap = g;
    repeat (2) @(negedge clk);
    lens.delete();
    enable = 1'b1;
  endtask

  task automatic wait_secs(input int n);
    while (lens.size() < n) @(negedge clk);
  endtask

  task automatic check_outputs_zero(input string tag);
    check_int(tag, "sec_tick", int'(sec_tick), 0);
    check_int(tag, "corr_sec", int'(corr_sec), 0);
    check_int(tag, "raw_taps", int'(raw_taps), 0);
    check_int(tag, "slow_taps", int'(slow_taps), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_outputs_zero("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs_zero("R1");

    // Positive trim, short window: last second shortened
    start_run(7'd5, 1'b0, 1'b0);
    wait_secs(10);
    for (int i = 0; i < 9; i++) check_int("R2", "nominal second", lens[i], NOM);
    check_int("R3", "positive trim length", lens[9], NOM - 5);
    check_int("R5", "short window position", lens[9], NOM - 5);

    // Negative trim, long window: only the 30th second changes
    start_run(7'b100_0101, 1'b1, 1'b0);
    wait_secs(30);
    check_int("R5", "10th second in long window", lens[9], NOM);
    check_int("R2", "29th second", lens[28], NOM);
    check_int("R3", "negative trim length", lens[29], NOM + 5);

    // Zero magnitude with either sign
    start_run(7'b100_0000, 1'b0, 1'b0);
    wait_secs(10);
    for (int i = 0; i < 10; i++) check_int("R4", "negative zero", lens[i], NOM);
    start_run(7'b000_0000, 1'b1, 1'b0);
    wait_secs(30);
    check_int("R4", "positive zero long", lens[29], NOM);

    // Trim extremes
    start_run(7'b011_1111, 1'b0, 1'b0);
    wait_secs(11);
    check_int("R3", "max positive trim", lens[9], NOM - 63);
    check_int("R2", "second after shortest", lens[10], NOM);
    start_run(7'b111_1111, 1'b0, 1'b0);
    wait_secs(10);
    check_int("R3", "max negative trim", lens[9], NOM + 63);

    // Mid-window change applies to the next window only
    start_run(7'd10, 1'b0, 1'b0);
    wait_secs(3);
    @(negedge clk);
    trim_code = 7'b100_1010;
    period_sel = 1'b1;
    wait_secs(40);
    check_int("R7", "old trim in current window", lens[9], NOM - 10);
    check_int("R7", "new window not yet corrected", lens[19], NOM);
    check_int("R7", "new trim and period", lens[39], NOM + 10);

    // Gapped reference enable
    start_run(7'd3, 1'b0, 1'b1);
    wait_secs(10);
    check_int("R9", "gapped nominal", lens[0], NOM);
    check_int("R9", "gapped corrected", lens[9], NOM - 3);

    // Disable mid-run, then restart fresh
    start_run(7'd0, 1'b0, 1'b0);
    wait_secs(2);
    repeat (17) @(negedge clk);
    enable = 1'b0;
    trim_code = 7'd7;
    @(negedge clk);
    check_outputs_zero("R8");
    repeat (5) @(negedge clk);
    check_outputs_zero("R8");
    lens.delete();
    enable = 1'b1;
    wait_secs(10);
    check_int("R8", "restart first second", lens[0], NOM);
    check_int("R8", "restart window with new trim", lens[9], NOM - 7);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule